// File: doc/BRIEF.md
# Register-Pointer I2C Target Interface

This block is the serial front end of a small peripheral with four byte-wide registers. It receives the raw SCL and SDA levels. Each line passes through a two-flop synchronizer and then a glitch filter. START and STOP conditions are found on the filtered levels, and the block answers to one 7-bit address. The upper four bits of that address are fixed. The lower three bits come from strap inputs, so up to eight such peripherals can share a bus.

After the address, a write transaction carries a command byte. Its low bits load a register pointer. Each data byte after that produces a one-cycle write strobe to the register that the pointer selects. A read transaction produces a one-cycle read strobe for each byte, and the selected register value is captured into the transmit shifter. The pointer never advances by itself, so consecutive bytes always go to the same register. A fetch from register 0, the input register, also raises a separate sample pulse so that downstream logic can clear its change indication.

The block only pulls SDA low. It drives a single open-drain enable. It does not stretch SCL.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The block acknowledges an address byte whose upper seven bits are 0100 followed by `addrPins[2:0]`. Any other address gets no acknowledge and produces no strobe.
- R2: The first byte after a write address is acknowledged and loads the pointer from its two low bits. Bits 7..2 of that byte are ignored.
- R3: Every later write data byte is acknowledged. It produces exactly one `wrStrobe` cycle, with `wrSel` equal to the pointer and `wrData` equal to the byte.
- R4: The pointer does not advance. Successive write bytes and successive read bytes all target the register last chosen by a command byte.
- R5: A data byte written while the pointer is 0 is acknowledged but produces no `wrStrobe`.
- R6: In a read, each byte is fetched with one `rdStrobe` cycle at the end of the preceding acknowledge. It is shifted out MSB first. After a master NACK the block leaves SDA released and fetches nothing more until the next START.
- R7: `inSample` pulses for one cycle with each fetch made while the pointer is 0, and at no other time.
- R8: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks has no effect. This means no false START, and no extra bit clocked in.
- R9: A START or a STOP in the middle of a byte abandons that byte without a strobe. The pointer keeps its value.
- R10: After reset, SDA is released, no strobe is active and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL level from the pad |
| sdaIn | input | 1 | Raw SDA level from the pad |
| addrPins | input | 3 | Strap bits, the low three bits of the address |
| sdaOe | output | 1 | 1 pulls SDA low |
| wrStrobe | output | 1 | One-cycle register write request |
| wrSel | output | 2 | Register targeted by the write |
| wrData | output | 8 | Byte to be written |
| rdStrobe | output | 1 | One-cycle register fetch request |
| rdSel | output | 2 | Register to be fetched (the pointer) |
| rdData | input | 8 | Value of the selected register, valid in the same cycle |
| inSample | output | 1 | Pulse when register 0 is fetched |

## Verification
The bench builds the block with `FILT_LEN` = 4. It runs SCL with 20-clock half periods, which is long compared with the roughly seven-cycle synchronizer and filter delay. The filter can then be probed with 3-clock pulses, which sit just below its acceptance threshold. The small 7-bit address space lets the bench sweep all 128 addresses against one strap value and then all eight strap values. Command bytes are swept with varying upper bits, and the expected register choice is computed as the value modulo 4. Reads, mid-byte aborts and filter pulses use a register model whose expected bytes are known to the bench.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_TXACK
  } busState_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic loadTx;
    logic shiftTx;
  } dpCtl_t;

endpackage

// File: rtl/i2cs_line_filter.sv
module i2cs_line_filter #(
  parameter int LANES    = 2,
  parameter int FILT_LEN = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LANES-1:0] rawIn,
  output logic [LANES-1:0] cleanOut
);
  localparam int CW = $clog2(FILT_LEN + 1);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [1:0]    syncQ;
    logic [CW-1:0] cnt;
    logic          cleanQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ  <= 2'b11;
        cnt    <= '0;
        cleanQ <= 1'b1;
      end else begin
        syncQ <= {syncQ[0], rawIn[g]};
        if (syncQ[1] == cleanQ) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
          cleanQ <= syncQ[1];
          cnt    <= '0;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end

    assign cleanOut[g] = cleanQ;
  end

endmodule

// File: rtl/i2cs_datapath.sv
module i2cs_datapath
  import i2cs_pkg::*;
#(
  parameter int PIN_W    = 3,
  parameter int NUM_REGS = 4,
  parameter logic [6-PIN_W:0] ADDR_HI = 4'b0100,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sdaF,
  input  dpCtl_t           ctl,
  input  logic [PIN_W-1:0] addrPins,
  input  logic [7:0]       rdData,
  output logic             addrMatch,
  output logic             rwBit,
  output logic             ptrZero,
  output logic             txBit,
  output logic [SEL_W-1:0] ptr,
  output logic [7:0]       rxByte
);
  logic [7:0] rxShift;
  logic [7:0] txShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
      ptr     <= '0;
    end else begin
      if (ctl.shiftIn) rxShift <= {rxShift[6:0], sdaF};
      if (ctl.loadPtr) ptr <= rxShift[SEL_W-1:0];
      if (ctl.loadTx) txShift <= rdData;
      else if (ctl.shiftTx) txShift <= {txShift[6:0], 1'b1};
    end
  end

  assign addrMatch = (rxShift[7:1] == {ADDR_HI, addrPins});
  assign rwBit     = rxShift[0];
  assign ptrZero   = (ptr == '0);
  assign txBit     = txShift[7];
  assign rxByte    = rxShift;

endmodule

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl
  import i2cs_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   sclF,
  input  logic   sdaF,
  input  logic   addrMatch,
  input  logic   rwBit,
  input  logic   ptrZero,
  input  logic   txBit,
  output dpCtl_t ctl,
  output logic   wrStrobe,
  output logic   rdStrobe,
  output logic   sdaOe
);
  busState_t state, stateN;
  phase_t    phase, phaseN;
  logic [3:0] bitCnt, bitCntN;
  logic isRead, isReadN;
  logic masterAck, masterAckN;
  logic sclQ, sdaQ;

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclF & ~sclQ;
  assign sclFall = ~sclF & sclQ;
  assign startEv = sclF & sclQ & sdaQ & ~sdaF;
  assign stopEv  = sclF & sclQ & ~sdaQ & sdaF;

  always_comb begin
    stateN     = state;
    phaseN     = phase;
    bitCntN    = bitCnt;
    isReadN    = isRead;
    masterAckN = masterAck;
    ctl        = '0;
    wrStrobe   = 1'b0;
    rdStrobe   = 1'b0;
    if (stopEv) begin
      stateN = ST_IDLE;
    end else if (startEv) begin
      stateN  = ST_RX;
      phaseN  = PH_ADDR;
      bitCntN = '0;
    end else begin
      case (state)
        ST_RX: begin
          if (sclRise && bitCnt < 4'd8) begin
            ctl.shiftIn = 1'b1;
            bitCntN     = bitCnt + 4'd1;
          end else if (sclFall && bitCnt == 4'd8) begin
            case (phase)
              PH_ADDR: begin
                if (addrMatch) begin
                  stateN  = ST_ACK;
                  isReadN = rwBit;
                end else begin
                  stateN = ST_IDLE;
                end
              end
              PH_CMD: begin
                ctl.loadPtr = 1'b1;
                stateN      = ST_ACK;
              end
              default: begin
                wrStrobe = ~ptrZero;
                stateN   = ST_ACK;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            bitCntN = '0;
            if (phase == PH_ADDR && isRead) begin
              rdStrobe   = 1'b1;
              ctl.loadTx = 1'b1;
              stateN     = ST_TX;
            end else begin
              stateN = ST_RX;
              phaseN = (phase == PH_ADDR) ? PH_CMD : PH_DATA;
            end
          end
        end
        ST_TX: begin
          if (sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = ST_TXACK;
            end else begin
              ctl.shiftTx = 1'b1;
              bitCntN     = bitCnt + 4'd1;
            end
          end
        end
        ST_TXACK: begin
          if (sclRise) begin
            masterAckN = ~sdaF;
          end else if (sclFall) begin
            if (masterAck) begin
              rdStrobe   = 1'b1;
              ctl.loadTx = 1'b1;
              stateN     = ST_TX;
              bitCntN    = '0;
            end else begin
              stateN = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      phase     <= PH_ADDR;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      masterAck <= 1'b0;
      sclQ      <= 1'b1;
      sdaQ      <= 1'b1;
    end else begin
      state     <= stateN;
      phase     <= phaseN;
      bitCnt    <= bitCntN;
      isRead    <= isReadN;
      masterAck <= masterAckN;
      sclQ      <= sclF;
      sdaQ      <= sdaF;
    end
  end

  assign sdaOe = (state == ST_ACK) | ((state == ST_TX) & ~txBit);

endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave
  import i2cs_pkg::*;
#(
  parameter int FILT_LEN = 8,
  parameter int PIN_W    = 3,
  parameter int NUM_REGS = 4,
  parameter logic [6-PIN_W:0] ADDR_HI = 4'b0100,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [PIN_W-1:0] addrPins,
  output logic             sdaOe,
  output logic             wrStrobe,
  output logic [SEL_W-1:0] wrSel,
  output logic [7:0]       wrData,
  output logic             rdStrobe,
  output logic [SEL_W-1:0] rdSel,
  input  logic [7:0]       rdData,
  output logic             inSample
);
  logic [1:0] cleanLines;
  logic sclF, sdaF;
  logic addrMatch, rwBit, ptrZero, txBit;
  logic [SEL_W-1:0] ptr;
  dpCtl_t ctl;

  i2cs_line_filter #(.LANES(2), .FILT_LEN(FILT_LEN)) u_filter (
    .clk(clk), .rstN(rstN), .rawIn({sdaIn, sclIn}), .cleanOut(cleanLines)
  );
  assign sclF = cleanLines[0];
  assign sdaF = cleanLines[1];

  i2cs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .sclF(sclF), .sdaF(sdaF),
    .addrMatch(addrMatch), .rwBit(rwBit), .ptrZero(ptrZero), .txBit(txBit),
    .ctl(ctl), .wrStrobe(wrStrobe), .rdStrobe(rdStrobe), .sdaOe(sdaOe)
  );

  i2cs_datapath #(
    .PIN_W(PIN_W), .NUM_REGS(NUM_REGS), .ADDR_HI(ADDR_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sdaF(sdaF), .ctl(ctl), .addrPins(addrPins),
    .rdData(rdData), .addrMatch(addrMatch), .rwBit(rwBit), .ptrZero(ptrZero),
    .txBit(txBit), .ptr(ptr), .rxByte(wrData)
  );

  assign wrSel    = ptr;
  assign rdSel    = ptr;
  assign inSample = rdStrobe & ptrZero;

endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int SEL_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             sdaOe,
  input logic             wrStrobe,
  input logic [SEL_W-1:0] wrSel,
  input logic             rdStrobe,
  input logic [SEL_W-1:0] rdSel,
  input logic             inSample
);
  AST_NO_INPUT_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> wrSel != '0); // R5
  AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |=> !wrStrobe); // R3
  AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> !rdStrobe); // R6
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStrobe && rdStrobe)); // R3
  AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobe |=> $stable(rdSel)); // R4
  AST_SAMPLE_WITH_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    inSample |-> rdStrobe); // R7
  AST_NO_DRIVE_ON_FETCH: assert property (@(posedge clk) disable iff (!rstN)
    wrStrobe |-> !sdaOe); // R3
endmodule

bind i2c_ptr_slave i2cs_checker #(.SEL_W(SEL_W)) u_chk (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .wrStrobe(wrStrobe), .wrSel(wrSel),
  .rdStrobe(rdStrobe), .rdSel(rdSel), .inSample(inSample)
);

// File: tb/test_i2c_ptr_slave.sv
`timescale 1ns/1ps
module test_i2c_ptr_slave;
  localparam int H = 20;
  localparam int FL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic [2:0] addrPins = 3'b101;
  logic sdaOe, wrStrobe, rdStrobe, inSample;
  logic [1:0] wrSel, rdSel;
  logic [7:0] wrData, rdData;
  logic [7:0] regModel [4];
  wire sdaBus = sdaM & ~sdaOe;

  int compared = 0, mismatched = 0;
  int wrCount = 0, rdCount = 0, inCount = 0;
  int lastWrSel = -1, lastWrData = -1, lastRdSel = -1;

  always #2.5 clk = ~clk;
  assign rdData = regModel[rdSel];

  i2c_ptr_slave #(.FILT_LEN(FL)) i_i2c_ptr_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrPins(addrPins),
    .sdaOe(sdaOe), .wrStrobe(wrStrobe), .wrSel(wrSel), .wrData(wrData),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .rdData(rdData), .inSample(inSample)
  );

  always @(negedge clk) if (rstN) begin
    if (wrStrobe) begin wrCount++; lastWrSel = wrSel; lastWrData = wrData; end
    if (rdStrobe) begin rdCount++; lastRdSel = rdSel; end
    if (inSample) inCount++;
  end

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic startCond();
    sdaM = 1; waitClk(H); sclM = 1; waitClk(H);
    sdaM = 0; waitClk(H); sclM = 0; waitClk(4);
  endtask

  task automatic stopCond();
    sdaM = 0; waitClk(H); sclM = 1; waitClk(H); sdaM = 1; waitClk(H);
  endtask

  task automatic writeBit(bit b);
    sdaM = b; waitClk(H); sclM = 1; waitClk(H); sclM = 0; waitClk(4);
  endtask

  task automatic readBit(output bit b);
    sdaM = 1; waitClk(H); sclM = 1; waitClk(H/2);
    b = sdaBus; waitClk(H/2); sclM = 0; waitClk(4);
  endtask

  // glitchAt >= 0 inserts a short SCL pulse before that bit
  task automatic writeByte(logic [7:0] v, output bit ack, input int glitchAt = -1);
    bit r;
    for (int i = 7; i >= 0; i--) begin
      if (i == glitchAt) begin
        sdaM = v[i]; waitClk(H/2);
        sclM = 1; waitClk(FL-1); sclM = 0; waitClk(H/2);
      end
      writeBit(v[i]);
    end
    readBit(r);
    ack = !r;
  endtask

  task automatic readByte(output logic [7:0] v, input bit ackIt);
    bit b;
    for (int i = 7; i >= 0; i--) begin readBit(b); v[i] = b; end
    writeBit(!ackIt);
  endtask

  localparam logic [3:0] HI = 4'b0100;
  bit ack;
  logic [7:0] rv;
  int w0, r0, i0;

  initial begin
    regModel[0] = 8'hC3; regModel[1] = 8'h5A; regModel[2] = 8'h81; regModel[3] = 8'h3E;
    waitClk(5); rstN = 1; waitClk(5);

    // R10: reset state
    check("R10 sdaOe after reset", sdaOe, 0);
    check("R10 no strobes after reset", wrStrobe | rdStrobe, 0);
    startCond(); writeByte({HI, addrPins, 1'b1}, ack);
    check("R10 ack read addr", ack, 1);
    readByte(rv, 0); stopCond();
    check("R10 pointer 0 data", rv, regModel[0]);
    check("R10 pointer 0 sel", lastRdSel, 0);
    check("R7 in sample on reg0 fetch", inCount, 1);

    // R1: sweep all addresses against strap 101
    for (int a = 0; a < 128; a++) begin
      w0 = wrCount; r0 = rdCount;
      startCond(); writeByte({a[6:0], 1'b0}, ack); stopCond();
      check("R1 address sweep ack", ack, (a == {HI, 3'b101}) ? 1 : 0);
      check("R1 no strobe", (wrCount - w0) + (rdCount - r0), 0);
    end

    // R1/R3/R5: strap sweep with command and data
    for (int s = 0; s < 8; s++) begin
      addrPins = s[2:0]; w0 = wrCount;
      startCond(); writeByte({HI, s[2:0], 1'b0}, ack);
      check("R1 strap ack", ack, 1);
      writeByte(8'(s), ack); check("R2 cmd ack", ack, 1);
      writeByte(8'(s * 37 + 1), ack); check("R3 data ack", ack, 1);
      stopCond();
      if (s % 4 == 0) check("R5 input write ignored", wrCount - w0, 0);
      else begin
        check("R3 one write strobe", wrCount - w0, 1);
        check("R3 write sel", lastWrSel, s % 4);
        check("R3 write data", lastWrData, (s * 37 + 1) & 8'hFF);
      end
    end
    addrPins = 3'b101;

    // R2: command upper bits ignored
    for (int k = 0; k < 16; k++) begin
      w0 = wrCount;
      startCond(); writeByte({HI, addrPins, 1'b0}, ack);
      writeByte(8'(k * 17), ack); check("R2 cmd ack sweep", ack, 1);
      writeByte(~8'(k * 17), ack); check("R3 data ack sweep", ack, 1);
      stopCond();
      if (k % 4 == 0) check("R5 sel0 no strobe", wrCount - w0, 0);
      else begin
        check("R2 sel from low bits", lastWrSel, k % 4);
        check("R3 data sweep", lastWrData, (~(k * 17)) & 8'hFF);
      end
    end

    // R4: no auto-increment on writes
    startCond(); writeByte({HI, addrPins, 1'b0}, ack); writeByte(8'h01, ack);
    for (int j = 1; j <= 3; j++) begin
      w0 = wrCount;
      writeByte(8'(j * 8'h11), ack);
      check("R4 write ack", ack, 1);
      check("R4 write count", wrCount - w0, 1);
      check("R4 sel stays", lastWrSel, 1);
      check("R4 data", lastWrData, j * 8'h11);
    end
    stopCond();

    // R6/R4: reads repeat the same register, stop after NACK
    startCond(); writeByte({HI, addrPins, 1'b0}, ack); writeByte(8'h02, ack);
    startCond(); writeByte({HI, addrPins, 1'b1}, ack);
    check("R6 read addr ack", ack, 1);
    r0 = rdCount; i0 = inCount;
    for (int j = 0; j < 3; j++) begin
      readByte(rv, j < 2);
      check("R6 read data", rv, regModel[2]);
      check("R4 read sel", lastRdSel, 2);
    end
    check("R6 fetch count", rdCount - r0, 3);
    check("R7 no sample off reg0", inCount - i0, 0);
    readByte(rv, 0);
    check("R6 released after nack", rv, 8'hFF);
    check("R6 no fetch after nack", rdCount - r0, 3);
    stopCond();

    // R7: reg0 reads pulse inSample each byte
    startCond(); writeByte({HI, addrPins, 1'b0}, ack); writeByte(8'h00, ack);
    startCond(); writeByte({HI, addrPins, 1'b1}, ack);
    i0 = inCount;
    readByte(rv, 1); readByte(rv, 0); stopCond();
    check("R7 sample per reg0 byte", inCount - i0, 2);
    check("R7 reg0 data", rv, regModel[0]);

    // R8: short SDA pulse while idle is no START
    sdaM = 0; waitClk(FL - 1); sdaM = 1; waitClk(H);
    sclM = 0; waitClk(H);
    w0 = wrCount; r0 = rdCount;
    writeByte({HI, addrPins, 1'b0}, ack);
    check("R8 no false start", ack, 0);
    stopCond();
    // R8: short SCL pulse inside a byte adds no bit
    startCond(); writeByte({HI, addrPins, 1'b0}, ack, 4);
    check("R8 scl pulse filtered ack", ack, 1);
    writeByte(8'h03, ack, 2); writeByte(8'h6D, ack, 6);
    stopCond();
    check("R8 write after pulses sel", lastWrSel, 3);
    check("R8 write after pulses data", lastWrData, 8'h6D);

    // R9: STOP mid-byte aborts, pointer kept
    w0 = wrCount;
    startCond(); writeByte({HI, addrPins, 1'b0}, ack); writeByte(8'h03, ack);
    for (int j = 0; j < 4; j++) writeBit(1'b1);
    stopCond();
    check("R9 stop abort no write", wrCount - w0, 0);
    startCond(); writeByte({HI, addrPins, 1'b1}, ack); readByte(rv, 0); stopCond();
    check("R9 pointer kept after stop", rv, regModel[3]);
    // R9: START mid-byte aborts, pointer kept
    w0 = wrCount;
    startCond(); writeByte({HI, addrPins, 1'b0}, ack); writeByte(8'h01, ack);
    for (int j = 0; j < 3; j++) writeBit(1'b0);
    startCond(); writeByte({HI, addrPins, 1'b1}, ack);
    check("R9 restart addr ack", ack, 1);
    readByte(rv, 0); stopCond();
    check("R9 start abort no write", wrCount - w0, 0);
    check("R9 pointer kept after start", lastRdSel, 1);
    check("R9 data after restart", rv, regModel[1]);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule